// File: doc/BRIEF.md
# Bulk Command Stream Register Decoder

This block sits behind a bulk byte transport, such as an endpoint receive FIFO, and turns a stream of framed commands into display-controller state. Each frame opens with a fixed lead byte and then an operation byte. A register-write frame carries a register address and a value. Those writes land in a small register file that holds the colour-depth selector, the blanking code and two 24-bit framebuffer base pointers.

A lock handshake on a reserved register address stages the writes. While the file is locked, writes reach only a shadow copy. The unlock write moves every shadow value into the live registers in one cycle. A copy frame carries a source pointer, a pixel count and a destination pointer. The block passes these fields to a renderer through a request port. The blanking register drives the horizontal-sync, vertical-sync and panel-power enables. A power-down code keeps all three off until the register file has been reconfigured.

The input stream uses a valid/ready handshake. The block accepts one byte on every cycle in which `s_valid` and `s_ready` are both high. It lowers `s_ready` only while a decoded copy request waits on `rq_ready`. The request port is valid/ready too. `rq_valid` and its fields stay steady until a cycle in which `rq_ready` is high. If `rq_ready` is held high, each copy frame costs the input at most one stall cycle.

Top module: `bulk_cmd_decoder`

## Requirements
- R1: A frame is lead byte 0xAF, then an operation byte. Operation 0x20 is a register write, followed by an address byte and then a value byte, four bytes in all.
- R2: While the file is unlocked, a register write reaches the live register and its outputs within four cycles after the value byte is accepted.
- R3: While the file is locked, a register write changes no output.
- R4: Writing 0x00 to address 0xFF locks the file. Writing 0xFF to address 0xFF unlocks it and moves all shadow values to the live registers at once. Any other value written to 0xFF is ignored.
- R5: Addresses 0x20, 0x21 and 0x22 give `base16` bits 23:16, 15:8 and 7:0. Addresses 0x26, 0x27 and 0x28 give `base8` in the same order.
- R6: Address 0x00 holds the depth selector on `depth_sel`: 0 selects 16 bpp, 1 selects 24 bpp split across both framebuffers.
- R7: The live blanking code at address 0x1F sets {hsync_on, vsync_on, panel_on}. Code 0x00 gives 1,1,1. Code 0x01 gives 0,0,1. Code 0x05 gives 0,1,1. Code 0x07 gives 0,0,0. Any other code gives 0,0,1. After reset the code is 0x00.
- R8: Once the live blanking code has been 0x07, all three enables stay 0 whatever the code becomes later. They return only after an unlock write that follows a write to a timing address (0x01 to 0x1E).
- R9: Operation 0x6A is a copy frame of nine bytes: a 3-byte source, a 1-byte count and a 3-byte destination, each pointer most significant byte first. These fields appear on `rq_src`, `rq_count` and `rq_dst` with `rq_valid` high. They hold steady until a cycle with `rq_ready` high.
- R10: `s_ready` is low only while a copy request is pending. No input byte is lost across a stall.
- R11: A lead byte other than 0xAF, or an unknown operation byte, sets `err_sticky`. This flag stays set until reset. Bytes are discarded until the next 0xAF, and the frames after that decode normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block can take a byte |
| s_data | input | 8 | Input byte |
| rq_valid | output | 1 | Copy request pending |
| rq_ready | input | 1 | Renderer takes the request |
| rq_src | output | 24 | Copy source pointer |
| rq_count | output | 8 | Copy pixel count |
| rq_dst | output | 24 | Copy destination pointer |
| err_sticky | output | 1 | Framing error seen since reset |
| depth_sel | output | 8 | Live colour-depth selector |
| base16 | output | 24 | Live 16 bpp framebuffer base |
| base8 | output | 24 | Live 8 bpp framebuffer base |
| hsync_on | output | 1 | Horizontal sync enabled |
| vsync_on | output | 1 | Vertical sync enabled |
| panel_on | output | 1 | Panel powered |

## Verification
Two events can fall on the same clock edge: the renderer accepting a pending copy request, and the input offering the first byte of the next frame. The bench holds `rq_ready` low after a copy frame while it keeps `s_valid` high with the next lead byte. It then releases `rq_ready` and completes a register write behind the stalled byte. A scoreboard queue judges the request fields. The base register output shows that the stalled byte was taken exactly once and not lost.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam logic [7:0] LEAD_BYTE  = 8'hAF;
  localparam logic [7:0] OP_REGWR   = 8'h20;
  localparam logic [7:0] OP_COPY    = 8'h6A;
  localparam logic [7:0] LOCK_ADDR  = 8'hFF;
  localparam logic [7:0] LOCK_VAL   = 8'h00;
  localparam logic [7:0] UNLOCK_VAL = 8'hFF;
  localparam logic [7:0] DEPTH_ADDR = 8'h00;
  localparam logic [7:0] BLANK_ADDR = 8'h1F;
  localparam logic [7:0] B16_ADDR   = 8'h20;
  localparam logic [7:0] B8_ADDR    = 8'h26;
  localparam logic [7:0] TIMING_LO  = 8'h01;
  localparam logic [7:0] TIMING_HI  = 8'h1E;
  localparam logic [7:0] PD_CODE    = 8'h07;

  localparam int PTR_BYTES    = 3;
  localparam int PTR_W        = 8 * PTR_BYTES;
  localparam int COPY_PAYLOAD = 2 * PTR_BYTES + 1;
  localparam int ACC_W        = 8 * (COPY_PAYLOAD - 1);
  localparam int NSLOT        = 2 + 2 * PTR_BYTES;
  localparam int CNT_W        = $clog2(COPY_PAYLOAD);

  typedef enum logic [2:0] {PS_HUNT, PS_OPC, PS_ADDR, PS_DATA, PS_COPY} pstate_t;

  // slot 0: depth, slot 1: blanking, then 16 bpp base bytes, then 8 bpp base bytes
  function automatic logic [7:0] slot_addr(input int idx);
    if (idx == 0)                  return DEPTH_ADDR;
    else if (idx == 1)             return BLANK_ADDR;
    else if (idx < 2 + PTR_BYTES)  return B16_ADDR + 8'(idx - 2);
    else                           return B8_ADDR + 8'(idx - 2 - PTR_BYTES);
  endfunction
endpackage

// File: rtl/bcd_parser.sv
module bcd_parser
  import bcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  output logic             rq_valid,
  input  logic             rq_ready,
  output logic [PTR_W-1:0] rq_src,
  output logic [7:0]       rq_count,
  output logic [PTR_W-1:0] rq_dst,
  output logic             wr_en,
  output logic [7:0]       wr_addr,
  output logic [7:0]       wr_data,
  output logic             err_sticky
);
  pstate_t          st;
  logic [7:0]       addr_q;
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign s_ready = !rq_valid;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= PS_HUNT;
      addr_q     <= '0;
      acc        <= '0;
      cnt        <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      err_sticky <= 1'b0;
      rq_valid   <= 1'b0;
      rq_src     <= '0;
      rq_count   <= '0;
      rq_dst     <= '0;
    end else begin
      wr_en <= 1'b0;
      if (rq_valid && rq_ready) rq_valid <= 1'b0;
      if (take) begin
        unique case (st)
          PS_HUNT: begin
            if (s_data == LEAD_BYTE) st <= PS_OPC;
            else err_sticky <= 1'b1;
          end
          PS_OPC: begin
            if (s_data == OP_REGWR) st <= PS_ADDR;
            else if (s_data == OP_COPY) begin
              st  <= PS_COPY;
              cnt <= '0;
            end else begin
              err_sticky <= 1'b1;
              st         <= PS_HUNT;
            end
          end
          PS_ADDR: begin
            addr_q <= s_data;
            st     <= PS_DATA;
          end
          PS_DATA: begin
            wr_en   <= 1'b1;
            wr_addr <= addr_q;
            wr_data <= s_data;
            st      <= PS_HUNT;
          end
          PS_COPY: begin
            acc <= {acc[ACC_W-9:0], s_data};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(COPY_PAYLOAD - 1)) begin
              rq_valid <= 1'b1;
              rq_src   <= acc[ACC_W-1 -: PTR_W];
              rq_count <= acc[ACC_W-PTR_W-1 -: 8];
              rq_dst   <= {acc[PTR_W-9:0], s_data};
              st       <= PS_HUNT;
            end
          end
          default: st <= PS_HUNT;
        endcase
      end
    end
  end

  // R1
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R9
  rq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_src) && $stable(rq_count) && $stable(rq_dst)));
  // R11
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
endmodule

// File: rtl/bcd_regfile.sv
module bcd_regfile
  import bcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [NSLOT*8-1:0] live_flat,
  output logic             unlock_evt,
  output logic             timing_wr
);
  logic [NSLOT*8-1:0] shadow_flat;
  logic               locked;
  logic               lock_evt;

  assign lock_evt   = wr_en && (wr_addr == LOCK_ADDR) && (wr_data == LOCK_VAL);
  assign unlock_evt = wr_en && (wr_addr == LOCK_ADDR) && (wr_data == UNLOCK_VAL);
  assign timing_wr  = wr_en && (wr_addr >= TIMING_LO) && (wr_addr <= TIMING_HI);

  always_ff @(posedge clk) begin
    if (!rst_n)          locked <= 1'b0;
    else if (lock_evt)   locked <= 1'b1;
    else if (unlock_evt) locked <= 1'b0;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_addr == slot_addr(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_flat[i*8 +: 8] <= '0;
        live_flat[i*8 +: 8]   <= '0;
      end else begin
        if (hit) shadow_flat[i*8 +: 8] <= wr_data;
        if (hit && !locked)  live_flat[i*8 +: 8] <= wr_data;
        else if (unlock_evt) live_flat[i*8 +: 8] <= shadow_flat[i*8 +: 8];
      end
    end
  end

  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && (wr_addr != LOCK_ADDR)) |=> $stable(live_flat));
  // R4
  unlock_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_evt |=> (live_flat == $past(shadow_flat)));
endmodule

// File: rtl/bcd_power.sv
module bcd_power
  import bcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] blank,
  input  logic       unlock_evt,
  input  logic       timing_wr,
  output logic       hsync_on,
  output logic       vsync_on,
  output logic       panel_on
);
  logic pd_latched;
  logic timing_seen;
  logic clr_pend;
  logic hs_c, vs_c, pw_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timing_seen <= 1'b0;
      clr_pend    <= 1'b0;
      pd_latched  <= 1'b0;
    end else begin
      clr_pend <= unlock_evt && timing_seen;
      if (unlock_evt)     timing_seen <= 1'b0;
      else if (timing_wr) timing_seen <= 1'b1;
      if (blank == PD_CODE) pd_latched <= 1'b1;
      else if (clr_pend)    pd_latched <= 1'b0;
    end
  end

  always_comb begin
    unique case (blank)
      8'h00:   {hs_c, vs_c, pw_c} = 3'b111;
      8'h05:   {hs_c, vs_c, pw_c} = 3'b011;
      PD_CODE: {hs_c, vs_c, pw_c} = 3'b000;
      default: {hs_c, vs_c, pw_c} = 3'b001;
    endcase
  end

  assign hsync_on = hs_c && !pd_latched;
  assign vsync_on = vs_c && !pd_latched;
  assign panel_on = pw_c && !pd_latched;

  // R8
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_latched |-> (!hsync_on && !vsync_on && !panel_on));
  // R7
  blank_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank == PD_CODE) |=> pd_latched);
endmodule

// File: rtl/bulk_cmd_decoder.sv
module bulk_cmd_decoder
  import bcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  output logic        rq_valid,
  input  logic        rq_ready,
  output logic [23:0] rq_src,
  output logic [7:0]  rq_count,
  output logic [23:0] rq_dst,
  output logic        err_sticky,
  output logic [7:0]  depth_sel,
  output logic [23:0] base16,
  output logic [23:0] base8,
  output logic        hsync_on,
  output logic        vsync_on,
  output logic        panel_on
);
  logic               wr_en;
  logic [7:0]         wr_addr;
  logic [7:0]         wr_data;
  logic [NSLOT*8-1:0] live_flat;
  logic               unlock_evt;
  logic               timing_wr;

  bcd_parser u_parser (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rq_src(rq_src), .rq_count(rq_count), .rq_dst(rq_dst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_sticky(err_sticky)
  );

  bcd_regfile u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .live_flat(live_flat), .unlock_evt(unlock_evt), .timing_wr(timing_wr)
  );

  bcd_power u_power (
    .clk(clk), .rst_n(rst_n),
    .blank(live_flat[15:8]), .unlock_evt(unlock_evt), .timing_wr(timing_wr),
    .hsync_on(hsync_on), .vsync_on(vsync_on), .panel_on(panel_on)
  );

  assign depth_sel = live_flat[7:0];

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_base
    assign base16[PTR_W-1-8*b -: 8] = live_flat[(2+b)*8 +: 8];
    assign base8[PTR_W-1-8*b -: 8]  = live_flat[(2+PTR_BYTES+b)*8 +: 8];
  end

  // R10
  ready_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |-> rq_valid);
endmodule

// File: tb/bulk_cmd_decoder_tb_top.sv
module bulk_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        rq_valid;
  logic        rq_ready = 1'b1;
  logic [23:0] rq_src;
  logic [7:0]  rq_count;
  logic [23:0] rq_dst;
  logic        err_sticky;
  logic [7:0]  depth_sel;
  logic [23:0] base16;
  logic [23:0] base8;
  logic        hsync_on, vsync_on, panel_on;

  int n_checks = 0;
  int n_fails  = 0;
  logic [55:0] exp_q[$];

  always #2 clk = ~clk;

  bulk_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rq_src(rq_src), .rq_count(rq_count), .rq_dst(rq_dst),
    .err_sticky(err_sticky), .depth_sel(depth_sel),
    .base16(base16), .base8(base8),
    .hsync_on(hsync_on), .vsync_on(vsync_on), .panel_on(panel_on)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  task automatic send_byte(input logic [7:0] b);
    s_valid = 1'b1;
    s_data  = b;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    s_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    send_byte(8'hAF); send_byte(8'h20); send_byte(a); send_byte(v);
    idle(4);
  endtask

  task automatic send_copy(input logic [23:0] src, input logic [7:0] cnt, input logic [23:0] dst);
    exp_q.push_back({src, cnt, dst});
    send_byte(8'hAF); send_byte(8'h6A);
    send_byte(src[23:16]); send_byte(src[15:8]); send_byte(src[7:0]);
    send_byte(cnt);
    send_byte(dst[23:16]); send_byte(dst[15:8]); send_byte(dst[7:0]);
  endtask

  task automatic check_sync(input logic [2:0] exp, input string req);
    check({hsync_on, vsync_on, panel_on} == exp, req, {hsync_on, vsync_on, panel_on}, exp);
  endtask

  // scoreboard monitor: R9 copy requests compared in order
  always @(negedge clk) begin
    #1;
    if (rst_n && rq_valid && rq_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected request", {rq_src, rq_count, rq_dst}, 0);
      else begin
        logic [55:0] e;
        e = exp_q.pop_front();
        check({rq_src, rq_count, rq_dst} == e, "R9 copy fields", {rq_src, rq_count, rq_dst}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R7)
    check(base16 == 0 && base8 == 0 && depth_sel == 0, "R5 reset bases", {base16, base8}, 0);
    check_sync(3'b111, "R7 reset enables");
    check(!err_sticky && !rq_valid && s_ready, "R10 reset handshake", {err_sticky, rq_valid, s_ready}, 3'b001);

    // R2 R5 unlocked writes
    wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
    check(base16 == 24'h123456, "R5 base16", base16, 24'h123456);
    wr(8'h26, 8'hAB); wr(8'h27, 8'hCD); wr(8'h28, 8'hEF);
    check(base8 == 24'hABCDEF, "R2 base8", base8, 24'hABCDEF);
    wr(8'h00, 8'h01);
    check(depth_sel == 8'h01, "R6 depth", depth_sel, 1);

    // R7 blanking codes
    wr(8'h1F, 8'h01); check_sync(3'b001, "R7 code01");
    wr(8'h1F, 8'h05); check_sync(3'b011, "R7 code05");
    wr(8'h1F, 8'h09); check_sync(3'b001, "R7 other code");

    // R3 R4 lock staging
    wr(8'hFF, 8'h00);
    wr(8'h20, 8'h77); wr(8'h1F, 8'h00);
    check(base16 == 24'h123456, "R3 locked base", base16, 24'h123456);
    check_sync(3'b001, "R3 locked blank");
    wr(8'hFF, 8'h55);
    check(base16 == 24'h123456, "R4 odd lock value", base16, 24'h123456);
    wr(8'hFF, 8'hFF);
    check(base16 == 24'h773456, "R4 unlock transfer", base16, 24'h773456);
    check_sync(3'b111, "R4 unlock blank");

    // R8 power-down latch
    wr(8'h1F, 8'h07); check_sync(3'b000, "R8 powerdown");
    wr(8'h1F, 8'h00); check_sync(3'b000, "R8 latch holds");
    wr(8'hFF, 8'h00); wr(8'hFF, 8'hFF);
    check_sync(3'b000, "R8 unlock without timing");
    wr(8'hFF, 8'h00); wr(8'h09, 8'h12); wr(8'hFF, 8'hFF);
    check_sync(3'b111, "R8 resume after mode set");

    // R1 R9 copy with ready high
    check(!err_sticky, "R1 clean stream", err_sticky, 0);
    rq_ready = 1'b1;
    send_copy(24'h010203, 8'h04, 24'h050607);
    send_copy(24'hA0B0C0, 8'hFF, 24'h00FF10);
    idle(3);
    check(exp_q.size() == 0, "R9 requests drained", exp_q.size(), 0);

    // R10 back-pressure with a byte waiting on the same edge
    rq_ready = 1'b0;
    send_copy(24'h111111, 8'h22, 24'h333333);
    s_valid = 1'b1; s_data = 8'hAF;
    repeat (4) begin
      check(rq_valid && !s_ready, "R10 stall held", {rq_valid, s_ready}, 2'b10);
      @(negedge clk);
    end
    rq_ready = 1'b1;
    send_byte(8'hAF); send_byte(8'h20); send_byte(8'h28); send_byte(8'h5A);
    idle(4);
    check(exp_q.size() == 0, "R10 request released", exp_q.size(), 0);
    check(base8 == 24'hABCD5A, "R10 stalled byte kept", base8, 24'hABCD5A);

    // R11 error recovery
    send_byte(8'hAF); send_byte(8'h33); idle(2);
    check(err_sticky, "R11 unknown op", err_sticky, 1);
    send_byte(8'h44); send_byte(8'h20);
    wr(8'h21, 8'h99);
    check(base16 == 24'h779956, "R11 resync write", base16, 24'h779956);
    check(err_sticky, "R11 sticky", err_sticky, 1);
    send_copy(24'h0000AA, 8'h01, 24'h0000BB);
    idle(3);
    check(exp_q.size() == 0, "R11 copy after error", exp_q.size(), 0);

    report();
    $finish;
  end
endmodule